// File: doc/BRIEF.md
# Programmable Length Serial Shift Register

This block is a serial shift register whose effective length can be set anywhere from 1 to 64 stages. Typical uses are a variable digital delay line or a register with an odd number of stages. A 2:1 selector picks the serial input from one of two data pins, so the output can be fed back to recirculate a stored pattern. The block gives a true and a complemented serial output.

The block runs on a single fast system clock. It samples the external shift clock and the active-low enable on that clock and turns their transitions into shift events. A rising shift clock while the enable is low is a shift event. A falling enable while the shift clock is high is also a shift event, so the enable can serve as a second, negative-edge clock. An asynchronous reset empties the register at once.

Internally the register is a fixed chain of 64 stages. The output is tapped at the stage whose index equals the length code. A change of length therefore shows up on the output at once, and no stored data is lost.

Top module: `prog_shift_reg`

## Requirements
- R1: The effective length is len_code + 1, where len_code bits 0..5 carry weights 1, 2, 4, 8, 16 and 32. A bit shifted in appears on q after exactly len_code + 1 shift events.
- R2: len_code = 0 gives a 1-stage register (q shows the last bit shifted in). len_code = 63 gives a 64-stage register.
- R3: When sel_a is 1 the bit shifted in comes from din_a. When sel_a is 0 it comes from din_b.
- R4: A 0-to-1 transition of shift_clk, sampled while shift_en_n is 0, causes exactly one shift.
- R5: A 1-to-0 transition of shift_en_n, sampled while shift_clk is 1, causes exactly one shift.
- R6: A rising shift_clk while shift_en_n is 1 is ignored, as is any cycle with no shift event. The stored contents, observed through q at every length code, are unchanged.
- R7: While rst is 1, the register is cleared asynchronously: q is 0 and q_n is 1 without waiting for a clock. After release every stage reads 0.
- R8: q_n is always the complement of q.
- R9: Changing len_code moves the output tap immediately. With no shift in between, q shows the bit stored at stage index len_code, counted from 0 at the input.
- R10: A rising shift_clk and a falling shift_en_n seen in the same sample produce one shift, not two. At most one shift occurs per system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples shift_clk and shift_en_n |
| rst | input | 1 | Asynchronous reset, active high |
| shift_clk | input | 1 | Shift clock; rising edge shifts while shift_en_n is low |
| shift_en_n | input | 1 | Active-low enable; its falling edge shifts while shift_clk is high |
| sel_a | input | 1 | Data select: 1 picks din_a, 0 picks din_b |
| din_a | input | 1 | Serial data input A |
| din_b | input | 1 | Serial data input B |
| len_code | input | 6 | Length code; length is len_code + 1 |
| q | output | 1 | Serial output from the selected stage |
| q_n | output | 1 | Complement of q |

## Verification
The checker watches the stage chain on every cycle. After a shift event, stage 0 must hold the selected input and every other stage must hold its neighbour's old value. With no event the chain must stay still. While reset is high q must be 0, q_n must always be the complement of q, and an event may only happen with the shift clock sampled high. Other behaviours are shown only by the bench's scenarios against a 64-entry reference model:
- edges ignored while the enable is high (R6);
- a simultaneous rise and fall giving a single shift (R10);
- the end lengths 1 and 64 (R2);
- immediate retapping on a length change (R9);
- asynchronous clearing between clock edges (R7).

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned PSR_STAGES = 64;
  localparam int unsigned PSR_CODE_W = $clog2(PSR_STAGES);

  // effective register length for a given length code
  function automatic int unsigned psr_length(input logic [PSR_CODE_W-1:0] code);
    return int'(code) + 1;
  endfunction

  // stage index that feeds the output for a given length code
  function automatic int unsigned psr_tap(input logic [PSR_CODE_W-1:0] code);
    return psr_length(code) - 1;
  endfunction

  // shift event from current and previous samples of clock and enable
  function automatic logic psr_event(input logic clk_now, input logic clk_prev,
                                     input logic en_n_now, input logic en_n_prev);
    logic rise_enabled;
    logic en_fall_clk_high;
    rise_enabled     = clk_now && !clk_prev && !en_n_now;
    en_fall_clk_high = !en_n_now && en_n_prev && clk_now;
    return rise_enabled || en_fall_clk_high;
  endfunction
endpackage

// File: rtl/psr_event_detect.sv
module psr_event_detect (
  input  logic clk,
  input  logic rst,
  input  logic shift_clk,
  input  logic shift_en_n,
  output logic sclk_smp,
  output logic shift_evt
);
  import psr_pkg::*;

  localparam int unsigned WARM_CYC = 2;

  logic sclk_prev;
  logic en_smp;
  logic en_prev;
  logic [WARM_CYC-1:0] warm;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sclk_smp  <= 1'b0;
      sclk_prev <= 1'b0;
      en_smp    <= 1'b1;
      en_prev   <= 1'b1;
      warm      <= '0;
    end else begin
      sclk_smp  <= shift_clk;
      sclk_prev <= sclk_smp;
      en_smp    <= shift_en_n;
      en_prev   <= en_smp;
      warm      <= {warm[WARM_CYC-2:0], 1'b1};
    end
  end

  // events are only trusted once both sample stages hold real input values
  assign shift_evt = warm[WARM_CYC-1] && psr_event(sclk_smp, sclk_prev, en_smp, en_prev);
endmodule

// File: rtl/psr_input_sel.sv
module psr_input_sel (
  input  logic sel_a,
  input  logic din_a,
  input  logic din_b,
  output logic din_sel
);
  always_comb begin
    if (sel_a) din_sel = din_a;
    else       din_sel = din_b;
  end
endmodule

// File: rtl/psr_stage_chain.sv
module psr_stage_chain #(
  parameter int unsigned STAGES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_evt,
  input  logic              din_sel,
  output logic [STAGES-1:0] stage_q
);
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic next_bit;
    if (i == 0) begin : g_head
      assign next_bit = din_sel;
    end else begin : g_body
      assign next_bit = stage_q[i-1];
    end

    always_ff @(posedge clk or posedge rst) begin
      if (rst)            stage_q[i] <= 1'b0;
      else if (shift_evt) stage_q[i] <= next_bit;
    end
  end
endmodule

// File: rtl/psr_tap_select.sv
module psr_tap_select #(
  parameter int unsigned STAGES = 64,
  localparam int unsigned CODE_W = $clog2(STAGES)
) (
  input  logic [STAGES-1:0] stage_q,
  input  logic [CODE_W-1:0] len_code,
  output logic              tap_bit
);
  import psr_pkg::*;

  always_comb begin
    tap_bit = 1'b0;
    for (int unsigned k = 0; k < STAGES; k++) begin
      if (psr_tap(len_code) == k) tap_bit = stage_q[k];
    end
  end
endmodule

// File: rtl/prog_shift_reg.sv
module prog_shift_reg #(
  parameter int unsigned STAGES = psr_pkg::PSR_STAGES,
  localparam int unsigned CODE_W = $clog2(STAGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_clk,
  input  logic              shift_en_n,
  input  logic              sel_a,
  input  logic              din_a,
  input  logic              din_b,
  input  logic [CODE_W-1:0] len_code,
  output logic              q,
  output logic              q_n
);
  logic              shift_evt;
  logic              sclk_smp;
  logic              din_sel;
  logic [STAGES-1:0] stage_q;
  logic              tap_bit;

  psr_event_detect u_evt (
    .clk        (clk),
    .rst        (rst),
    .shift_clk  (shift_clk),
    .shift_en_n (shift_en_n),
    .sclk_smp   (sclk_smp),
    .shift_evt  (shift_evt)
  );

  psr_input_sel u_sel (
    .sel_a   (sel_a),
    .din_a   (din_a),
    .din_b   (din_b),
    .din_sel (din_sel)
  );

  psr_stage_chain #(.STAGES(STAGES)) u_chain (
    .clk       (clk),
    .rst       (rst),
    .shift_evt (shift_evt),
    .din_sel   (din_sel),
    .stage_q   (stage_q)
  );

  psr_tap_select #(.STAGES(STAGES)) u_tap (
    .stage_q  (stage_q),
    .len_code (len_code),
    .tap_bit  (tap_bit)
  );

  assign q   = tap_bit;
  assign q_n = ~tap_bit;
endmodule

// File: rtl/psr_checker.sv
module psr_checker #(
  parameter int unsigned STAGES = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              shift_evt,
  input logic              sclk_smp,
  input logic [STAGES-1:0] stage_q,
  input logic              sel_a,
  input logic              din_a,
  input logic              din_b,
  input logic              q,
  input logic              q_n
);
  // R3: stage 0 takes the selected serial input on a shift
  a_r3_head_takes_selected: assert property (@(posedge clk) disable iff (rst)
    shift_evt |=> stage_q[0] == $past(sel_a ? din_a : din_b));

  // R1: every later stage takes its neighbour's old value on a shift
  a_r1_chain_advances: assert property (@(posedge clk) disable iff (rst)
    shift_evt |=> stage_q[STAGES-1:1] == $past(stage_q[STAGES-2:0]));

  // R6: no event, no change
  a_r6_hold_without_event: assert property (@(posedge clk) disable iff (rst)
    !shift_evt |=> $stable(stage_q));

  // R7: output low while reset is held
  a_r7_reset_output_low: assert property (@(posedge clk)
    rst |-> (!q && q_n));

  // R8: complement relation
  a_r8_complement: assert property (@(posedge clk) disable iff (rst)
    q_n == !q);

  // R4 and R5: both event kinds need the shift clock sampled high
  a_r5_event_needs_clk_high: assert property (@(posedge clk) disable iff (rst)
    shift_evt |-> sclk_smp);
endmodule

bind prog_shift_reg psr_checker #(.STAGES(STAGES)) u_psr_checker (
  .clk       (clk),
  .rst       (rst),
  .shift_evt (shift_evt),
  .sclk_smp  (sclk_smp),
  .stage_q   (stage_q),
  .sel_a     (sel_a),
  .din_a     (din_a),
  .din_b     (din_b),
  .q         (q),
  .q_n       (q_n)
);

// File: tb/tb_prog_shift_reg.sv
module tb_prog_shift_reg;
  localparam int unsigned N = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_clk = 1'b0;
  logic shift_en_n = 1'b1;
  logic sel_a = 1'b0;
  logic din_a = 1'b0;
  logic din_b = 1'b0;
  logic [5:0] len_code = '0;
  logic q;
  logic q_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [N-1:0] model = '0;

  always #5 clk = ~clk;

  prog_shift_reg dut (
    .clk(clk), .rst(rst), .shift_clk(shift_clk), .shift_en_n(shift_en_n),
    .sel_a(sel_a), .din_a(din_a), .din_b(din_b), .len_code(len_code),
    .q(q), .q_n(q_n)
  );

  function automatic logic exp_q(input logic [N-1:0] m, input logic [5:0] code);
    return m[code];
  endfunction

  function automatic logic [N-1:0] model_shift(input logic [N-1:0] m, input logic s,
                                               input logic a, input logic b);
    return {m[N-2:0], (s ? a : b)};
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b time=%0t", req, act, exp, $time);
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_outputs(input string req);
    check(req, q, exp_q(model, len_code));
    check("R8", q_n, ~exp_q(model, len_code));
  endtask

  // every stored bit via the output port, by sweeping the length code
  task automatic scan_all(input string req);
    logic [5:0] keep;
    keep = len_code;
    for (int k = 0; k < N; k++) begin
      len_code = 6'(k);
      #1;
      check(req, q, model[k]);
    end
    len_code = keep;
    #1;
  endtask

  task automatic rise_shift(input logic s, input logic a, input logic b);
    sel_a = s; din_a = a; din_b = b;
    shift_en_n = 1'b0;
    settle(3);
    shift_clk = 1'b1;
    settle(3);
    shift_clk = 1'b0;
    settle(3);
    model = model_shift(model, s, a, b);
  endtask

  task automatic fall_shift(input logic s, input logic a, input logic b);
    sel_a = s; din_a = a; din_b = b;
    shift_en_n = 1'b1;
    settle(3);
    shift_clk = 1'b1;   // rise with enable high: ignored
    settle(3);
    shift_en_n = 1'b0;  // falling enable while clock high: shift
    settle(3);
    shift_clk = 1'b0;
    settle(2);
    shift_en_n = 1'b1;
    settle(3);
    model = model_shift(model, s, a, b);
  endtask

  initial begin
    process_watch: begin
      #1_500_000;
      if (!done) begin
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4417));
    #1;
    // reset state
    check("R7", q, 1'b0);
    check("R7", q_n, 1'b1);
    settle(3);
    rst = 1'b0;
    settle(5);
    scan_all("R7");

    // R2 / R1: single stage and full 64 stages
    len_code = 6'd0;
    rise_shift(1'b1, 1'b1, 1'b0);
    check_outputs("R2");
    len_code = 6'd63;
    for (int i = 0; i < 62; i++) rise_shift(1'b0, 1'b1, 1'b0);
    check_outputs("R1");
    rise_shift(1'b0, 1'b1, 1'b0);
    check("R2", q, 1'b1);

    // R3: select picks A or B
    len_code = 6'd0;
    rise_shift(1'b1, 1'b1, 1'b0);
    check("R3", q, 1'b1);
    rise_shift(1'b0, 1'b1, 1'b0);
    check("R3", q, 1'b0);
    rise_shift(1'b0, 1'b0, 1'b1);
    check("R3", q, 1'b1);

    // R5: enable as falling-edge clock
    fall_shift(1'b1, 1'b0, 1'b1);
    check("R5", q, 1'b0);
    fall_shift(1'b0, 1'b0, 1'b1);
    check("R5", q, 1'b1);
    scan_all("R5");

    // R6: clock toggles with enable high are ignored
    shift_en_n = 1'b1;
    sel_a = 1'b1; din_a = ~model[0]; din_b = ~model[0];
    for (int i = 0; i < 4; i++) begin
      shift_clk = 1'b1; settle(3);
      shift_clk = 1'b0; settle(3);
    end
    scan_all("R6");

    // R10: clock rises and enable falls in the same sample -> one shift
    shift_clk = 1'b0; shift_en_n = 1'b1; sel_a = 1'b1; din_a = ~model[0];
    settle(3);
    shift_clk = 1'b1; shift_en_n = 1'b0;
    settle(4);
    shift_clk = 1'b0;
    settle(2);
    shift_en_n = 1'b1;
    settle(3);
    model = model_shift(model, 1'b1, din_a, din_b);
    scan_all("R10");

    // R9: retap without shifting
    for (int k = 0; k < 8; k++) begin
      len_code = 6'($urandom_range(0, 63));
      #1;
      check_outputs("R9");
    end

    // random mix of R4 and R5 shifts
    for (int i = 0; i < 400; i++) begin
      logic s, a, b;
      s = 1'($urandom); a = 1'($urandom); b = 1'($urandom);
      len_code = 6'($urandom_range(0, 63));
      if ($urandom_range(0, 3) == 0) fall_shift(s, a, b);
      else                            rise_shift(s, a, b);
      check_outputs("R4");
    end
    scan_all("R1");

    // R7: asynchronous reset between clock edges
    @(posedge clk);
    #2;
    rst = 1'b1;
    #1;
    check("R7", q, 1'b0);
    check("R7", q_n, 1'b1);
    model = '0;
    settle(2);
    rst = 1'b0;
    settle(5);
    scan_all("R7");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule